// File: doc/BRIEF.md
# Integer Execute Stage for Register and Immediate Arithmetic

This block computes the integer result of one 32-bit base-ISA arithmetic instruction, either a register-register operation or a register-immediate operation. It receives the full instruction word and two source values. It decodes the operation from the major opcode, the funct3 field and instruction bit 30. It takes the immediate from the instruction itself, and it returns the value destined for the destination register together with a flag that marks encodings it does not accept.

The arithmetic is combinational. It sits behind a single output register that uses a valid/ready handshake, so it fits into a pipeline directly. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge, and it stays there unchanged until the consumer raises `out_ready`. While an undelivered result is held, `in_ready` is low. A new instruction can be accepted in the same cycle the held result leaves, so the stage sustains one instruction per clock when the consumer never stalls.

Top module: `int_exec_stage`

## Requirements
- R1: An instruction is taken when `in_valid` and `in_ready` are both high at a rising edge, and its result is presented with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_result` and `out_illegal` hold their values.
- R2: After reset, `out_valid`, `out_result` and `out_illegal` are 0 and `in_ready` is 1.
- R3: With register opcode 0110011 and funct3 000, the result is rs1+rs2 when bit 30 is 0 and rs1-rs2 when bit 30 is 1, modulo 2^32.
- R4: With immediate opcode 0010011 and funct3 000, the result is rs1 plus the sign-extended insn[31:20]. Bit 30 never turns this into a subtraction.
- R5: funct3 100, 110 and 111 give bitwise XOR, OR and AND of rs1 with rs2 (register form) or with the sign-extended immediate (immediate form).
- R6: funct3 010 gives 1 if rs1 is less than the second operand as signed numbers, otherwise 0. funct3 011 does the same comparison unsigned. The immediate form sign-extends the immediate first and then compares it unsigned.
- R7: funct3 001 shifts left, and funct3 101 shifts right, logically when bit 30 is 0 and arithmetically (sign fill) when it is 1. The register form uses rs2[4:0] as the amount, and the immediate form uses insn[24:20].
- R8: In the immediate form, `in_rs2` has no effect on the result.
- R9: `out_illegal` is 1 and `out_result` is 0 in any of these cases: the opcode is neither 0110011 nor 0010011; a register opcode has insn[31:25] other than 0000000, except 0100000 with funct3 000 or 101; or an immediate shift has insn[31:25] other than 0000000, except 0100000 for funct3 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Stage can take an instruction this cycle |
| in_insn | input | 32 | Instruction word |
| in_rs1 | input | 32 | First source value |
| in_rs2 | input | 32 | Second source value (register form only) |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Value for the destination register |
| out_illegal | output | 1 | Encoding not accepted by the stage |

## Verification
The bench builds the stage with its default width of 32. At this width the five-bit shift amount covers every distance up to 31, including the full sign smear. Carries and borrows leave the word at the 2^32 boundary, and a twelve-bit immediate of 0xfff becomes all ones, which is the largest unsigned value. Back-pressure is exercised by holding `out_ready` low across several cycles while a second instruction waits at the input.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_SLT  = 3'b010;
  localparam logic [2:0] F3_SLTU = 3'b011;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SHL, K_LTS, K_LTU, K_XOR, K_SHR, K_SHA, K_OR, K_AND
  } exec_kind_e;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] rs2,
  output exec_kind_e      kind,
  output logic [XLEN-1:0] opnd_b,
  output logic            bad
);
  localparam int SHW = $clog2(XLEN);
  localparam int FW  = 12 - SHW;
  localparam logic [FW-1:0] ALT = FW'(1 << (FW - 2));

  logic [6:0]    opc;
  logic [2:0]    f3;
  logic          alt_bit;
  logic [6:0]    f7;
  logic [FW-1:0] shi;
  logic          is_reg, is_imm;
  logic [XLEN-1:0] imm_sx;

  assign opc     = insn[6:0];
  assign f3      = insn[14:12];
  assign alt_bit = insn[30];
  assign f7      = insn[31:25];
  assign shi     = insn[31:20+SHW];
  assign is_reg  = (opc == OPC_REG);
  assign is_imm  = (opc == OPC_IMM);
  assign imm_sx  = {{(XLEN-12){insn[31]}}, insn[31:20]};

  // The shift amount is opnd_b's low bits in both forms, as imm[4:0] = insn[24:20].
  assign opnd_b = is_imm ? imm_sx : rs2;

  always_comb begin
    unique case (f3)
      F3_ADD:  kind = (is_reg && alt_bit) ? K_SUB : K_ADD;
      F3_SLL:  kind = K_SHL;
      F3_SLT:  kind = K_LTS;
      F3_SLTU: kind = K_LTU;
      F3_XOR:  kind = K_XOR;
      F3_SR:   kind = alt_bit ? K_SHA : K_SHR;
      F3_OR:   kind = K_OR;
      default: kind = K_AND;
    endcase
  end

  always_comb begin
    bad = 1'b0;
    if (is_reg) begin
      bad = !((f7 == 7'b0000000) ||
              (f7 == 7'b0100000 && (f3 == F3_ADD || f3 == F3_SR)));
    end else if (is_imm) begin
      if (f3 == F3_SLL)
        bad = (shi != '0);
      else if (f3 == F3_SR)
        bad = !((shi == '0) || (shi == ALT));
    end else begin
      bad = 1'b1;
    end
  end

endmodule

// File: rtl/int_exec_shift.sv
module int_exec_shift #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         val,
  input  logic [$clog2(XLEN)-1:0] amt,
  input  logic                    left,
  input  logic                    arith,
  output logic [XLEN-1:0]         res
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] rev_in, rev_out;
  logic [XLEN-1:0] stg [SHW+1];
  logic            fill;

  // Left shifts reuse the right-shift network on a bit-reversed word.
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev_in[i]  = val[XLEN-1-i];
    assign rev_out[i] = stg[SHW][XLEN-1-i];
  end

  assign fill   = arith & !left & val[XLEN-1];
  assign stg[0] = left ? rev_in : val;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][XLEN-1:D]} : stg[s];
  end

  assign res = left ? rev_out : stg[SHW];

endmodule

// File: rtl/int_exec_core.sv
module int_exec_core
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exec_kind_e      kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] sh_res;

  int_exec_shift #(.XLEN(XLEN)) u_shift (
    .val   (a),
    .amt   (b[SHW-1:0]),
    .left  (kind == K_SHL),
    .arith (kind == K_SHA),
    .res   (sh_res)
  );

  always_comb begin
    unique case (kind)
      K_ADD:   y = a + b;
      K_SUB:   y = a - b;
      K_LTS:   y = XLEN'($signed(a) < $signed(b));
      K_LTU:   y = XLEN'(a < b);
      K_XOR:   y = a ^ b;
      K_OR:    y = a | b;
      K_AND:   y = a & b;
      default: y = sh_res;
    endcase
  end

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  exec_kind_e      kind;
  logic [XLEN-1:0] opnd_b, y;
  logic            bad, take;

  int_exec_decode #(.XLEN(XLEN)) u_dec (
    .insn   (in_insn),
    .rs2    (in_rs2),
    .kind   (kind),
    .opnd_b (opnd_b),
    .bad    (bad)
  );

  int_exec_core #(.XLEN(XLEN)) u_core (
    .kind (kind),
    .a    (in_rs1),
    .b    (opnd_b),
    .y    (y)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= bad ? '0 : y;
        out_illegal <= bad;
      end
    end
  end

  // R1: a stalled result stays put
  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal));

  // R1: an accepted instruction produces a result next cycle
  a_r1_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R3: register subtraction wraps modulo 2^XLEN
  a_r3_sub_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bad && in_insn[6:0] == OPC_REG && in_insn[14:12] == F3_ADD && in_insn[30]
    |=> out_result == $past(in_rs1) - $past(in_rs2));

  // R4: immediate add never subtracts
  a_r4_addi_adds: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_insn[6:0] == OPC_IMM && in_insn[14:12] == F3_ADD
    |=> out_result == $past(in_rs1) + $past({{(XLEN-12){in_insn[31]}}, in_insn[31:20]}));

  // R6: comparisons yield only 0 or 1
  a_r6_compare_bit: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bad && (kind == K_LTS || kind == K_LTU) |=> out_result[XLEN-1:1] == '0);

  // R9: rejected encodings are flagged with a zero result
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0);

endmodule

// File: tb/test_int_exec_stage.sv
module test_int_exec_stage;

  localparam int NV = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_rs1 = '0;
  logic [31:0] in_rs2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_stage i_int_exec_stage (
    .clk, .rst_n, .in_valid, .in_ready, .in_insn, .in_rs1, .in_rs2,
    .out_valid, .out_ready, .out_result, .out_illegal
  );

  function automatic logic [31:0] r_ins(input logic [6:0] f7, input logic [2:0] f3);
    return {f7, 5'd3, 5'd1, f3, 5'd2, 7'b0110011};
  endfunction

  function automatic logic [31:0] i_ins(input logic [11:0] imm, input logic [2:0] f3);
    return {imm, 5'd1, f3, 5'd2, 7'b0010011};
  endfunction

  function automatic logic [132:0] mk(input logic [31:0] ins, input logic [31:0] a,
                                      input logic [31:0] b, input logic [31:0] e,
                                      input logic ill, input logic [3:0] rq);
    return {ins, a, b, e, ill, rq};
  endfunction

  localparam logic [132:0] VEC [NV] = '{
    mk(r_ins(7'h00, 3'd0), 32'h81111111, 32'h22222222, 32'ha3333333, 1'b0, 4'd3), // R3 add
    mk(r_ins(7'h20, 3'd0), 32'h83333333, 32'h01111111, 32'h82222222, 1'b0, 4'd3), // R3 sub
    mk(r_ins(7'h00, 3'd0), 32'hffffffff, 32'h00000002, 32'h00000001, 1'b0, 4'd3), // R3 carry out
    mk(r_ins(7'h20, 3'd0), 32'h00000000, 32'h00000001, 32'hffffffff, 1'b0, 4'd3), // R3 borrow
    mk(i_ins(12'h400, 3'd0), 32'h00000005, 32'hdeadbeef, 32'h00000405, 1'b0, 4'd4), // R4 bit30 set
    mk(i_ins(12'hfff, 3'd0), 32'h00000010, 32'h00000000, 32'h0000000f, 1'b0, 4'd4), // R4 negative
    mk(r_ins(7'h00, 3'd4), 32'h83333333, 32'h1888ffff, 32'h9bbbcccc, 1'b0, 4'd5), // R5 xor
    mk(r_ins(7'h00, 3'd6), 32'h83333333, 32'h00000440, 32'h83333773, 1'b0, 4'd5), // R5 or
    mk(r_ins(7'h00, 3'd7), 32'h83333333, 32'h00000fe2, 32'h00000322, 1'b0, 4'd5), // R5 and
    mk(i_ins(12'hfff, 3'd4), 32'h0000ff00, 32'h12345678, 32'hffff00ff, 1'b0, 4'd5), // R5 xori
    mk(i_ins(12'h0f0, 3'd7), 32'h12345678, 32'hffffffff, 32'h00000070, 1'b0, 4'd5), // R5 andi
    mk(i_ins(12'h800, 3'd6), 32'h00000001, 32'h00000000, 32'hfffff801, 1'b0, 4'd5), // R5 ori
    mk(r_ins(7'h00, 3'd2), 32'h83333333, 32'h00000002, 32'h00000001, 1'b0, 4'd6), // R6 signed
    mk(r_ins(7'h00, 3'd3), 32'h83333333, 32'h00000002, 32'h00000000, 1'b0, 4'd6), // R6 unsigned
    mk(r_ins(7'h00, 3'd3), 32'h00000000, 32'h00000005, 32'h00000001, 1'b0, 4'd6), // R6 nonzero test
    mk(r_ins(7'h00, 3'd3), 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 4'd6), // R6 zero test
    mk(i_ins(12'hfff, 3'd3), 32'h81111111, 32'h00000000, 32'h00000001, 1'b0, 4'd6), // R6 imm all ones
    mk(i_ins(12'h004, 3'd3), 32'h81111111, 32'h00000000, 32'h00000000, 1'b0, 4'd6), // R6 imm small
    mk(i_ins(12'hfff, 3'd2), 32'hfffffffe, 32'h00000000, 32'h00000001, 1'b0, 4'd6), // R6 -2 < -1
    mk(i_ins(12'h004, 3'd2), 32'h11111111, 32'h00000000, 32'h00000000, 1'b0, 4'd6), // R6
    mk(r_ins(7'h00, 3'd1), 32'h83333333, 32'h00000002, 32'h0ccccccc, 1'b0, 4'd7), // R7 sll
    mk(r_ins(7'h00, 3'd1), 32'h83333333, 32'h00000022, 32'h0ccccccc, 1'b0, 4'd7), // R7 low 5 bits
    mk(r_ins(7'h00, 3'd5), 32'h83333333, 32'h00000010, 32'h00008333, 1'b0, 4'd7), // R7 srl
    mk(r_ins(7'h20, 3'd5), 32'h83333333, 32'h00000010, 32'hffff8333, 1'b0, 4'd7), // R7 sra
    mk(i_ins(12'h002, 3'd1), 32'h81111111, 32'h00000000, 32'h04444444, 1'b0, 4'd7), // R7 slli
    mk(i_ins(12'h002, 3'd5), 32'h81111111, 32'h00000000, 32'h20444444, 1'b0, 4'd7), // R7 srli
    mk(i_ins(12'h402, 3'd5), 32'h81111111, 32'h00000000, 32'he0444444, 1'b0, 4'd7), // R7 srai
    mk(i_ins(12'h41f, 3'd5), 32'h80000000, 32'h00000000, 32'hffffffff, 1'b0, 4'd7), // R7 srai 31
    mk(i_ins(12'h001, 3'd5), 32'h00000010, 32'h0000001f, 32'h00000008, 1'b0, 4'd8), // R8 rs2 ignored
    mk(i_ins(12'h402, 3'd1), 32'h00000001, 32'h00000000, 32'h00000000, 1'b1, 4'd9), // R9 slli alt
    mk(i_ins(12'h202, 3'd5), 32'h00000001, 32'h00000000, 32'h00000000, 1'b1, 4'd9), // R9 bad upper
    mk(r_ins(7'h01, 3'd0), 32'h00000003, 32'h00000004, 32'h00000000, 1'b1, 4'd9), // R9 funct7 01
    mk({12'h0, 5'd1, 3'd2, 5'd2, 7'b0000011}, 32'h1, 32'h2, 32'h0, 1'b1, 4'd9),   // R9 opcode
    mk(r_ins(7'h20, 3'd4), 32'h00000003, 32'h00000004, 32'h00000000, 1'b1, 4'd9)  // R9 alt xor
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_insn  = ins;
    in_rs1   = a;
    in_rs2   = b;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", {30'd0, out_valid, out_illegal}, 32'd0);
    check("R2", out_result, 32'd0);
    check("R2", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [132:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d", v[3:0]);
      send(v[132:101], v[100:69], v[68:37]);
      @(negedge clk);
      check(tag, {31'd0, out_valid}, 32'd1);
      check(tag, out_result, v[36:5]);
      check(tag, {31'd0, out_illegal}, {31'd0, v[4]});
    end

    // R1: back-pressure holds the first result and blocks the second
    @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
    send(r_ins(7'h00, 3'd0), 32'd10, 32'd20);
    @(negedge clk);
    in_insn = r_ins(7'h20, 3'd0); in_rs1 = 32'd50; in_rs2 = 32'd8; in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      check("R1", {30'd0, out_valid, in_ready}, 32'd2);
      check("R1", out_result, 32'd30);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #0.5 check("R1", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R1", out_result, 32'd42);
    check("R1", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);

    // R8: same shift-immediate with different rs2 gives the same result
    send(i_ins(12'h004, 3'd1), 32'h00000001, 32'hffffffff);
    @(negedge clk);
    check("R8", out_result, 32'h00000010);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule